// File: doc/BRIEF.md
# Protected Register Unlock Sequencer

This block keeps one 8-bit control register behind an unlock ritual of bus stores. It snoops a plain peripheral write bus (address, data, write strobe). A store of the key byte A5h to a command register arms it. After that, three stores to the guarded register must follow: the intended value, then its bitwise inverse, then the intended value again. Only the last of these changes the guarded register. Any store to another address while the ritual is open, or a data mismatch, aborts the attempt. A store to the guarded register while nothing is armed has the same effect. An abort leaves the guarded register untouched and raises a sticky protection-error flag.

An 8-bit status register carries that protection-error flag and two error flags from self-programming. Pulse inputs from the erase/write verify logic and from the write-protect checker set those two flags. Software clears any flag by writing 0 to its bit. A combinational read port returns the status register, the guarded register, or zero for the write-only command register.

Top module: `prot_unlock_seq`

## Requirements
- R1: After reset the status register (FFA1h) reads 00h, the guarded register (FFA2h) reads 00h and the sequencer is idle.
- R2: The store sequence A5h to FFA0h, then V, ~V and V to FFA2h, loads V into the guarded register on the clock edge of the fourth store and leaves status bit 0 clear.
- R3: The guarded register keeps its old value after the second and third stores of the sequence.
- R4: While the sequence is open, any store to an address other than FFA2h, including FFA0h and FFA1h, aborts it and sets status bit 0. The sequencer returns to idle, so later stores to FFA2h are not accepted until a new key.
- R5: A third store whose data is not the inverse of the held value aborts the sequence, sets status bit 0 and leaves the guarded register unchanged.
- R6: A fourth store whose data differs from the held value aborts the sequence, sets status bit 0 and leaves the guarded register unchanged.
- R7: A store to FFA2h while the sequencer is idle is ignored and sets status bit 0.
- R8: A store to FFA0h with data other than A5h leaves the sequencer idle without setting any flag.
- R9: An erase-verify or write-verify failure pulse sets status bit 1. A write-protect error pulse sets status bit 2.
- R10: Writing to FFA1h clears each flag whose data bit is 0 and keeps each flag whose data bit is 1. Bits 7 to 3 always read 0.
- R11: When a flag's set event and a software clear of that flag fall in the same cycle, the flag ends up set.
- R12: Reads of FFA0h return 00h. Reads of FFA2h return the guarded register. Reads of FFA1h return the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one store per high cycle |
| bus_addr | input | 16 | Write address |
| bus_wdata | input | 8 | Write data |
| bus_rd_addr | input | 16 | Read address |
| bus_rdata | output | 8 | Read data, combinational |
| erase_vfy_fail | input | 1 | Erase-verify failure pulse |
| write_vfy_fail | input | 1 | Internal write-verify failure pulse |
| wprot_fail | input | 1 | Write-protect error pulse |
| guard_q | output | 8 | Current guarded register value |

## Verification
The bench aims at the places where an unlock scheme usually breaks. It stores to the wrong address mid-sequence, which a design that only watched the guarded address would silently step past. It sends a second key mid-sequence, which a design might treat as a fresh start instead of an abort. It sends near-miss inverse and final values, which a design comparing only part of the byte would accept. It uses a guarded value equal to the key, which would confuse a design that mixed up data paths. It also writes a bad key and follows it with a bare guarded store, which a design that armed on any command store would wrongly accept. It fires a hardware set in the same cycle as a software clear, where a clear-priority design would lose the event. Finally it writes ones to the status register, which a toggle-style or plain-write design would corrupt.

// File: rtl/prot_unlock_pkg.sv
package prot_unlock_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ARMED = 2'd1,
    SEQ_VAL   = 2'd2,
    SEQ_INV   = 2'd3
  } seq_state_t;
endpackage

// File: rtl/prot_unlock_fsm.sv
module prot_unlock_fsm
  import prot_unlock_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter logic [15:0] CMD_ADDR  = 16'hFFA0,
  parameter logic [15:0] GUARD_ADDR = 16'hFFA2,
  parameter logic [7:0]  KEY       = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] guard_q,
  output logic              prot_err
);
  seq_state_t        state_q, state_d;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              hold_en;
  logic              commit;
  logic              hit_cmd, hit_guard;

  assign hit_cmd   = wr && (addr == CMD_ADDR[ADDR_W-1:0]);
  assign hit_guard = wr && (addr == GUARD_ADDR[ADDR_W-1:0]);

  always_comb begin
    state_d  = state_q;
    hold_d   = hold_q;
    hold_en  = 1'b0;
    commit   = 1'b0;
    prot_err = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (hit_cmd && (wdata == KEY[DATA_W-1:0])) begin
          state_d = SEQ_ARMED;
        end else if (hit_guard) begin
          prot_err = 1'b1;
        end
      end
      SEQ_ARMED: begin
        if (hit_guard) begin
          state_d = SEQ_VAL;
          hold_d  = wdata;
          hold_en = 1'b1;
        end else if (wr) begin
          state_d  = SEQ_IDLE;
          prot_err = 1'b1;
        end
      end
      SEQ_VAL: begin
        if (hit_guard && (wdata == ~hold_q)) begin
          state_d = SEQ_INV;
        end else if (wr) begin
          state_d  = SEQ_IDLE;
          prot_err = 1'b1;
        end
      end
      SEQ_INV: begin
        if (hit_guard && (wdata == hold_q)) begin
          state_d = SEQ_IDLE;
          commit  = 1'b1;
        end else if (wr) begin
          state_d  = SEQ_IDLE;
          prot_err = 1'b1;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (hold_en) begin
      hold_q <= hold_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      guard_q <= '0;
    end else if (commit) begin
      guard_q <= hold_q;
    end
  end

  AST_GUARD_ONLY_ON_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(guard_q) |-> ($past(state_q) == SEQ_INV)); // R3
  AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    prot_err |=> (state_q == SEQ_IDLE)); // R4
  AST_FOREIGN_STORE_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != SEQ_IDLE && wr && !hit_guard) |-> prot_err); // R4
endmodule

// File: rtl/prot_status_flags.sv
module prot_status_flags #(
  parameter int NFLAG  = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NFLAG-1:0]  set_ev,
  input  logic              sw_wr,
  input  logic [DATA_W-1:0] sw_data,
  output logic [DATA_W-1:0] status
);
  logic [NFLAG-1:0] flag_q, flag_d, clr;

  generate
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      assign clr[i]    = sw_wr && !sw_data[i];
      assign flag_d[i] = set_ev[i] | (flag_q[i] & ~clr[i]);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          flag_q[i] <= 1'b0;
        end else begin
          flag_q[i] <= flag_d[i];
        end
      end

      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_ev[i] |=> flag_q[i]); // R11
      AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[i]) |-> $past(set_ev[i])); // R10
    end
  endgenerate

  assign status = {{(DATA_W-NFLAG){1'b0}}, flag_q};
endmodule

// File: rtl/prot_read_mux.sv
module prot_read_mux #(
  parameter int          ADDR_W     = 16,
  parameter int          DATA_W     = 8,
  parameter logic [15:0] STAT_ADDR  = 16'hFFA1,
  parameter logic [15:0] GUARD_ADDR = 16'hFFA2
) (
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] status,
  input  logic [DATA_W-1:0] guard_q,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    if (rd_addr == STAT_ADDR[ADDR_W-1:0]) begin
      rdata = status;
    end else if (rd_addr == GUARD_ADDR[ADDR_W-1:0]) begin
      rdata = guard_q;
    end else begin
      rdata = '0;
    end
  end
endmodule

// File: rtl/prot_unlock_seq.sv
module prot_unlock_seq #(
  parameter int          ADDR_W     = 16,
  parameter int          DATA_W     = 8,
  parameter logic [15:0] CMD_ADDR   = 16'hFFA0,
  parameter logic [15:0] STAT_ADDR  = 16'hFFA1,
  parameter logic [15:0] GUARD_ADDR = 16'hFFA2,
  parameter logic [7:0]  KEY        = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [ADDR_W-1:0] bus_rd_addr,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              erase_vfy_fail,
  input  logic              write_vfy_fail,
  input  logic              wprot_fail,
  output logic [DATA_W-1:0] guard_q
);
  localparam int NFLAG = 3;

  logic             prot_err;
  logic [NFLAG-1:0] set_ev;
  logic             stat_wr;
  logic [DATA_W-1:0] status;

  prot_unlock_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_ADDR(CMD_ADDR),
    .GUARD_ADDR(GUARD_ADDR), .KEY(KEY)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .guard_q(guard_q), .prot_err(prot_err)
  );

  assign set_ev  = {wprot_fail, erase_vfy_fail | write_vfy_fail, prot_err};
  assign stat_wr = bus_wr && (bus_addr == STAT_ADDR[ADDR_W-1:0]);

  prot_status_flags #(.NFLAG(NFLAG), .DATA_W(DATA_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_ev(set_ev), .sw_wr(stat_wr),
    .sw_data(bus_wdata), .status(status)
  );

  prot_read_mux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_ADDR(STAT_ADDR),
    .GUARD_ADDR(GUARD_ADDR)
  ) u_rmux (
    .rd_addr(bus_rd_addr), .status(status), .guard_q(guard_q),
    .rdata(bus_rdata)
  );

  AST_VFY_SETS_BIT1: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_vfy_fail || write_vfy_fail) |=> status[1]); // R9
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status[DATA_W-1:NFLAG] == '0); // R10
endmodule

// File: tb/prot_unlock_seq_bench.sv
module prot_unlock_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [15:0] bus_rd_addr = '0;
  logic [7:0]  bus_rdata;
  logic        erase_vfy_fail = 1'b0;
  logic        write_vfy_fail = 1'b0;
  logic        wprot_fail = 1'b0;
  logic [7:0]  guard_q;

  localparam logic [15:0] A_CMD = 16'hFFA0;
  localparam logic [15:0] A_STAT = 16'hFFA1;
  localparam logic [15:0] A_GUARD = 16'hFFA2;

  typedef struct {
    logic [15:0] addr;
    logic [7:0]  exp;
    string       tag;
  } item_t;

  item_t sb_q[$];
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  prot_unlock_seq u_prot_unlock_seq (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rd_addr(bus_rd_addr), .bus_rdata(bus_rdata),
    .erase_vfy_fail(erase_vfy_fail), .write_vfy_fail(write_vfy_fail),
    .wprot_fail(wprot_fail), .guard_q(guard_q)
  );

  task automatic store(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic expect_rd(input logic [15:0] a, input logic [7:0] e, input string tag);
    item_t it;
    @(negedge clk);
    bus_rd_addr = a;
    it.addr = a; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic clear_all();
    store(A_STAT, 8'h00);
  endtask

  task automatic unlock(input logic [7:0] v);
    store(A_CMD, 8'hA5);
    store(A_GUARD, v);
    store(A_GUARD, ~v);
    store(A_GUARD, v);
  endtask

  always @(posedge clk) begin
    item_t it;
    #2;
    if (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      n_checks++;
      if (bus_rdata !== it.exp) begin
        n_fail++;
        $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, bus_rdata, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_rd(A_STAT, 8'h00, "R1 status");
    expect_rd(A_GUARD, 8'h00, "R1 guard");
    expect_rd(A_CMD, 8'h00, "R12 cmd reads 0");

    // full sequence, observe between steps
    store(A_CMD, 8'hA5);
    store(A_GUARD, 8'h3C);
    expect_rd(A_GUARD, 8'h00, "R3 after step2");
    store(A_GUARD, 8'hC3);
    expect_rd(A_GUARD, 8'h00, "R3 after step3");
    store(A_GUARD, 8'h3C);
    expect_rd(A_GUARD, 8'h3C, "R2 committed");
    expect_rd(A_STAT, 8'h00, "R2 no error");
    expect_rd(A_CMD, 8'h00, "R12 cmd still 0");

    // idle store to guard
    store(A_GUARD, 8'h55);
    expect_rd(A_GUARD, 8'h3C, "R7 ignored");
    expect_rd(A_STAT, 8'h01, "R7 error set");
    store(A_STAT, 8'hFF);
    expect_rd(A_STAT, 8'h01, "R10 write-1 keeps");
    store(A_STAT, 8'hFE);
    expect_rd(A_STAT, 8'h00, "R10 write-0 clears");

    // bad inverse
    store(A_CMD, 8'hA5); store(A_GUARD, 8'h11); store(A_GUARD, 8'hEF);
    expect_rd(A_STAT, 8'h01, "R5 error");
    expect_rd(A_GUARD, 8'h3C, "R5 unchanged");
    clear_all();

    // bad final
    store(A_CMD, 8'hA5); store(A_GUARD, 8'h11); store(A_GUARD, 8'hEE);
    store(A_GUARD, 8'h10);
    expect_rd(A_STAT, 8'h01, "R6 error");
    expect_rd(A_GUARD, 8'h3C, "R6 unchanged");
    clear_all();

    // foreign store mid sequence, then stale continuation
    store(A_CMD, 8'hA5); store(A_GUARD, 8'h11);
    store(16'h0040, 8'hAB);
    expect_rd(A_STAT, 8'h01, "R4 foreign abort");
    clear_all();
    store(A_GUARD, 8'hEE);
    expect_rd(A_STAT, 8'h01, "R4 back to idle");
    store(A_GUARD, 8'h11);
    expect_rd(A_GUARD, 8'h3C, "R4 no commit after abort");
    clear_all();

    // second key mid sequence
    store(A_CMD, 8'hA5); store(A_GUARD, 8'h22); store(A_GUARD, 8'hDD);
    store(A_CMD, 8'hA5);
    expect_rd(A_STAT, 8'h01, "R4 key mid sequence aborts");
    clear_all();
    store(A_GUARD, 8'h22);
    expect_rd(A_GUARD, 8'h3C, "R4 key did not rearm");
    clear_all();

    // status store mid sequence
    store(A_CMD, 8'hA5); store(A_STAT, 8'hFF);
    expect_rd(A_STAT, 8'h01, "R4 status store aborts");
    clear_all();

    // wrong key
    store(A_CMD, 8'h5A);
    expect_rd(A_STAT, 8'h00, "R8 bad key no error");
    store(A_GUARD, 8'h77);
    expect_rd(A_STAT, 8'h01, "R8 still idle");
    expect_rd(A_GUARD, 8'h3C, "R8 unchanged");
    clear_all();

    // hardware flags
    @(negedge clk); erase_vfy_fail = 1'b1; @(negedge clk); erase_vfy_fail = 1'b0;
    expect_rd(A_STAT, 8'h02, "R9 erase verify");
    store(A_STAT, 8'hFD);
    expect_rd(A_STAT, 8'h00, "R10 clear bit1");
    @(negedge clk); write_vfy_fail = 1'b1; @(negedge clk); write_vfy_fail = 1'b0;
    expect_rd(A_STAT, 8'h02, "R9 write verify");
    @(negedge clk); wprot_fail = 1'b1; @(negedge clk); wprot_fail = 1'b0;
    expect_rd(A_STAT, 8'h06, "R9 write protect");
    store(A_STAT, 8'hFB);
    expect_rd(A_STAT, 8'h02, "R10 selective clear");
    clear_all();
    expect_rd(A_STAT, 8'h00, "R10 cleared");

    // set vs clear in the same cycle
    @(negedge clk);
    wprot_fail = 1'b1; bus_wr = 1'b1; bus_addr = A_STAT; bus_wdata = 8'h00;
    @(negedge clk);
    wprot_fail = 1'b0; bus_wr = 1'b0;
    expect_rd(A_STAT, 8'h04, "R11 set wins");
    clear_all();

    // value equal to key, and zero value
    unlock(8'hA5);
    expect_rd(A_GUARD, 8'hA5, "R2 value equal to key");
    unlock(8'h00);
    expect_rd(A_GUARD, 8'h00, "R2 zero value");
    expect_rd(A_STAT, 8'h00, "R2 clean status");

    wait (sb_q.size() == 0);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule